// File: doc/BRIEF.md
# Microsecond Timing-Sync Counter with Beacon Scheduling

This block keeps a 64-bit local time count that advances by one on each microsecond tick. Software corrects it against a remote station by loading a signed correction into a two-half offset register and then raising an offset-sync control bit. The correction is added to the running count on the following cycle. A combinational helper produces the correction from a received beacon timestamp and the rate index of that beacon. The helper removes a fixed receive latency that depends on the rate.

A second function schedules beacons. A sequential divider takes the current count and a 16-bit interval, given in units of 1024 µs. It rounds the count up to the next strictly later multiple of that span and writes the result into the two-half target register. Software then raises a target-sync bit, and the target is copied into the live comparator. From then on a one-cycle beacon-due pulse is raised each time the count reaches the target, and the target moves on by one span after every pulse. A read-latch bit copies the count into two 32-bit snapshot registers.

Top module: `tsf_beacon_timer`

## Requirements
- R1: After reset the count is 0. It rises by exactly 1 on each cycle with `tick_i` high and holds otherwise (an offset add is the only exception).
- R2: `calc_ofs_o` = `bcn_ts_i` − (count + L), modulo 2^64. L is taken from the table {17,17,17,17,34,23,17,11,8,5,4,3} µs, indexed by `bcn_rate_i` mod 12.
- R3: `calc_apply_o` is high only when `bcn_valid_i` is high and `bcn_ts_i` differs from the count.
- R4: Writing 1 to control bit 1 (register address 5) adds the offset register {addr 1, addr 0} to the count on the next clock edge. The bit then reads back 0.
- R5: Writing the offset halves (addr 0 low, addr 1 high) or the target halves (addr 2 low, addr 3 high) leaves the count unchanged. The written values read back at the same addresses.
- R6: Writing 1 to control bit 0 copies the count into the snapshot registers (addr 6 low, addr 7 high) on the next edge. The bit then reads back 0.
- R7: Writing 1 to control bit 3 starts the rounding. For interval I at addr 4, nonzero, it writes (floor(C/(I·1024))+1)·I·1024 into the target registers, with C the count at the start. `busy_o` stays high for exactly 64 cycles. When I is 0, C is written unchanged.
- R8: Writing 1 to control bit 2 loads the target into the comparator. `bcn_due_o` then pulses for one cycle on the edge after the count first reaches the target, and the target advances by I·1024.
- R9: A start of the rounding while `busy_o` is high is ignored. It changes neither the result nor the busy length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational); addr 5 shows pending bits 0..2 and busy in bit 4 |
| bcn_valid_i | input | 1 | Received beacon timestamp is present |
| bcn_ts_i | input | 64 | Received beacon timestamp |
| bcn_rate_i | input | 8 | Rate index of the received beacon |
| calc_ofs_o | output | 64 | Latency-corrected offset for the beacon |
| calc_apply_o | output | 1 | Offset is worth applying |
| tsf_o | output | 64 | Current count |
| busy_o | output | 1 | Rounding divider running |
| bcn_due_o | output | 1 | Beacon-due pulse |

## Verification
The rounding is swept over a grid of intervals: 1, 3, 100, the maximum and zero. Each is paired with counts of zero, just below a span boundary, exactly on one, a large value and a value near the top of the range. This separates the strictly-later rounding from rounding to the nearest multiple, and separates the zero-interval bypass from the divider path. Every rate index from 0 to 23 goes through the offset helper, so the modulo wrap of the table is tested. A timestamp equal to the count and one behind it test the apply flag and the negative wrap. The due pulse is watched across two periods to confirm the sample on which it lands and the advance of the target.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [2:0] {
    A_OFS_LO  = 3'd0,
    A_OFS_HI  = 3'd1,
    A_TGT_LO  = 3'd2,
    A_TGT_HI  = 3'd3,
    A_IVAL    = 3'd4,
    A_CTRL    = 3'd5,
    A_SNAP_LO = 3'd6,
    A_SNAP_HI = 3'd7
  } reg_addr_e;

  localparam int CTRL_LATCH = 0;
  localparam int CTRL_OSYNC = 1;
  localparam int CTRL_TSYNC = 2;
  localparam int CTRL_CALC  = 3;
  localparam int STAT_BUSY  = 4;
  localparam int N_RATES    = 12;

  // receive latency in us per rate slot
  function automatic logic [5:0] rx_latency(input int unsigned rate);
    logic [5:0] l;
    case (rate % N_RATES)
      4:       l = 6'd34;
      5:       l = 6'd23;
      7:       l = 6'd11;
      8:       l = 6'd8;
      9:       l = 6'd5;
      10:      l = 6'd4;
      11:      l = 6'd3;
      default: l = 6'd17;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/tsf_ofs_calc.sv
module tsf_ofs_calc #(
  parameter int TSF_W  = 64,
  parameter int RATE_W = 8
) (
  input  logic [TSF_W-1:0]  count_i,
  input  logic [TSF_W-1:0]  ts_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              valid_i,
  output logic [TSF_W-1:0]  ofs_o,
  output logic              apply_o
);
  import tsf_pkg::*;
  logic [TSF_W-1:0] lat;

  always_comb begin
    lat     = TSF_W'(rx_latency(32'(rate_i)));
    ofs_o   = ts_i - (count_i + lat);
    apply_o = valid_i && (ts_i != count_i);
  end
endmodule

// File: rtl/tsf_counter.sv
module tsf_counter #(
  parameter int TSF_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             add_en_i,
  input  logic [TSF_W-1:0] add_val_i,
  input  logic             snap_en_i,
  output logic [TSF_W-1:0] count_o,
  output logic [TSF_W-1:0] snap_o
);
  logic [TSF_W-1:0] add;

  always_comb add = (add_en_i ? add_val_i : '0) + TSF_W'(tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      snap_o  <= '0;
    end else begin
      count_o <= count_o + add;
      if (snap_en_i) snap_o <= count_o;
    end
  end
endmodule

// File: rtl/tsf_next_tbtt.sv
module tsf_next_tbtt #(
  parameter int TSF_W    = 64,
  parameter int BI_W     = 16,
  parameter int TU_SHIFT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TSF_W-1:0] count_i,
  input  logic [BI_W-1:0]  ival_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [TSF_W-1:0] tbtt_o
);
  localparam int DVS_W = BI_W + TU_SHIFT;
  localparam int CNT_W = $clog2(TSF_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TSF_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [TSF_W-1:0] dvd_sh, orig;
  logic [DVS_W-1:0] dvs, rem, rem_n;
  logic [DVS_W:0]   sh, sub;

  always_comb begin
    sh    = {rem, dvd_sh[TSF_W-1]};
    sub   = sh - {1'b0, dvs};
    rem_n = (sh >= {1'b0, dvs}) ? sub[DVS_W-1:0] : sh[DVS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      tbtt_o <= '0;
      cnt    <= '0;
      dvd_sh <= '0;
      orig   <= '0;
      dvs    <= '0;
      rem    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        if (ival_i == '0) begin
          tbtt_o <= count_i;
          done_o <= 1'b1;
        end else begin
          busy_o <= 1'b1;
          dvd_sh <= count_i;
          orig   <= count_i;
          dvs    <= {ival_i, {TU_SHIFT{1'b0}}};
          rem    <= '0;
          cnt    <= '0;
        end
      end else if (busy_o) begin
        rem    <= rem_n;
        dvd_sh <= dvd_sh << 1;
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          // (q+1)*d == C - r + d
          tbtt_o <= orig - TSF_W'(rem_n) + TSF_W'(dvs);
        end
      end
    end
  end
endmodule

// File: rtl/tsf_beacon_timer.sv
module tsf_beacon_timer #(
  parameter int TSF_W    = 64,
  parameter int BI_W     = 16,
  parameter int TU_SHIFT = 10,
  parameter int RATE_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [TSF_W/2-1:0] wr_data_i,
  input  logic [2:0]         rd_addr_i,
  output logic [TSF_W/2-1:0] rd_data_o,
  input  logic               bcn_valid_i,
  input  logic [TSF_W-1:0]   bcn_ts_i,
  input  logic [RATE_W-1:0]  bcn_rate_i,
  output logic [TSF_W-1:0]   calc_ofs_o,
  output logic               calc_apply_o,
  output logic [TSF_W-1:0]   tsf_o,
  output logic               busy_o,
  output logic               bcn_due_o
);
  import tsf_pkg::*;
  localparam int HW = TSF_W / 2;

  logic [TSF_W-1:0] ofs_q, tgt_q, tgt_act, snap_q, tbtt;
  logic [BI_W-1:0]  ival_q;
  logic             latch_pend, ofs_pend, tgt_pend, armed, calc_done;
  logic             ctrl_wr, calc_start;
  logic [TSF_W-1:0] span;

  always_comb begin
    ctrl_wr    = wr_en_i && (wr_addr_i == A_CTRL);
    calc_start = ctrl_wr && wr_data_i[CTRL_CALC];
    span       = TSF_W'({ival_q, {TU_SHIFT{1'b0}}});
  end

  tsf_ofs_calc #(.TSF_W(TSF_W), .RATE_W(RATE_W)) u_ofs (
    .count_i(tsf_o), .ts_i(bcn_ts_i), .rate_i(bcn_rate_i),
    .valid_i(bcn_valid_i), .ofs_o(calc_ofs_o), .apply_o(calc_apply_o)
  );

  tsf_counter #(.TSF_W(TSF_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .add_en_i(ofs_pend), .add_val_i(ofs_q), .snap_en_i(latch_pend),
    .count_o(tsf_o), .snap_o(snap_q)
  );

  tsf_next_tbtt #(.TSF_W(TSF_W), .BI_W(BI_W), .TU_SHIFT(TU_SHIFT)) u_div (
    .clk_i, .rst_ni, .start_i(calc_start), .count_i(tsf_o), .ival_i(ival_q),
    .busy_o, .done_o(calc_done), .tbtt_o(tbtt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q      <= '0;
      tgt_q      <= '0;
      ival_q     <= '0;
      latch_pend <= 1'b0;
      ofs_pend   <= 1'b0;
      tgt_pend   <= 1'b0;
    end else begin
      latch_pend <= ctrl_wr && wr_data_i[CTRL_LATCH];
      ofs_pend   <= ctrl_wr && wr_data_i[CTRL_OSYNC];
      tgt_pend   <= ctrl_wr && wr_data_i[CTRL_TSYNC];
      if (wr_en_i) begin
        case (wr_addr_i)
          A_OFS_LO: ofs_q[HW-1:0]     <= wr_data_i;
          A_OFS_HI: ofs_q[TSF_W-1:HW] <= wr_data_i;
          A_IVAL:   ival_q            <= wr_data_i[BI_W-1:0];
          default: ;
        endcase
      end
      if (calc_done) tgt_q <= tbtt;
      else if (wr_en_i && wr_addr_i == A_TGT_LO) tgt_q[HW-1:0] <= wr_data_i;
      else if (wr_en_i && wr_addr_i == A_TGT_HI) tgt_q[TSF_W-1:HW] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_act   <= '0;
      armed     <= 1'b0;
      bcn_due_o <= 1'b0;
    end else begin
      bcn_due_o <= 1'b0;
      if (tgt_pend) begin
        tgt_act <= tgt_q;
        armed   <= 1'b1;
      end else if (armed && tsf_o >= tgt_act) begin
        bcn_due_o <= 1'b1;
        if (span == '0) armed <= 1'b0;
        else tgt_act <= tgt_act + span;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_OFS_LO:  rd_data_o = ofs_q[HW-1:0];
      A_OFS_HI:  rd_data_o = ofs_q[TSF_W-1:HW];
      A_TGT_LO:  rd_data_o = tgt_q[HW-1:0];
      A_TGT_HI:  rd_data_o = tgt_q[TSF_W-1:HW];
      A_IVAL:    rd_data_o = HW'(ival_q);
      A_CTRL: begin
        rd_data_o[CTRL_LATCH] = latch_pend;
        rd_data_o[CTRL_OSYNC] = ofs_pend;
        rd_data_o[CTRL_TSYNC] = tgt_pend;
        rd_data_o[STAT_BUSY]  = busy_o;
      end
      A_SNAP_LO: rd_data_o = snap_q[HW-1:0];
      A_SNAP_HI: rd_data_o = snap_q[TSF_W-1:HW];
      default: ;
    endcase
  end
endmodule

// File: rtl/tsf_beacon_timer_chk.sv
module tsf_beacon_timer_chk #(
  parameter int TSF_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [TSF_W-1:0] tsf_o,
  input logic             ofs_pend,
  input logic [TSF_W-1:0] ofs_q,
  input logic             latch_pend,
  input logic [TSF_W-1:0] snap_q,
  input logic             tgt_pend,
  input logic [TSF_W-1:0] tgt_q,
  input logic [TSF_W-1:0] tgt_act,
  input logic             armed
);
  assert_count_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ofs_pend && tick_i) |=> tsf_o == $past(tsf_o) + 1'b1);

  assert_count_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ofs_pend && !tick_i) |=> $stable(tsf_o));

  assert_ofs_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_pend && !tick_i) |=> tsf_o == $past(tsf_o) + $past(ofs_q));

  assert_ofs_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_pend |=> !ofs_pend);

  assert_latch_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_pend |=> (!latch_pend && snap_q == $past(tsf_o)));

  assert_tgt_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_pend |=> (armed && tgt_act == $past(tgt_q)));
endmodule

bind tsf_beacon_timer tsf_beacon_timer_chk #(.TSF_W(TSF_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tsf_o(tsf_o),
  .ofs_pend(ofs_pend), .ofs_q(ofs_q), .latch_pend(latch_pend), .snap_q(snap_q),
  .tgt_pend(tgt_pend), .tgt_q(tgt_q), .tgt_act(tgt_act), .armed(armed)
);

// File: tb/tsf_beacon_timer_tb.sv
module tsf_beacon_timer_tb_top;
  import tsf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        bcn_valid = 1'b0;
  logic [63:0] bcn_ts = '0;
  logic [7:0]  bcn_rate = '0;
  logic [63:0] calc_ofs, tsf;
  logic        calc_apply, busy, due;

  int n_cmp = 0;
  int n_bad = 0;
  int due_seen = 0;
  logic [63:0] due_at [4];

  always #4 clk = ~clk;

  tsf_beacon_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .bcn_valid_i(bcn_valid), .bcn_ts_i(bcn_ts), .bcn_rate_i(bcn_rate),
    .calc_ofs_o(calc_ofs), .calc_apply_o(calc_apply), .tsf_o(tsf),
    .busy_o(busy), .bcn_due_o(due)
  );

  always @(negedge clk) if (rst_n && due) begin
    if (due_seen < 4) due_at[due_seen] = tsf;
    due_seen++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [63:0] lat_ref(input int r);
    int t [12] = '{17, 17, 17, 17, 34, 23, 17, 11, 8, 5, 4, 3};
    return 64'(t[r % 12]);
  endfunction

  task automatic set_count(input logic [63:0] v);
    logic [63:0] o;
    @(negedge clk);
    o = v - tsf;
    wr(A_OFS_LO, o[31:0]);
    wr(A_OFS_HI, o[63:32]);
    wr(A_CTRL, 32'h2);
    @(negedge clk);
    chk("R4 offset add", tsf, v);
  endtask

  task automatic calc_check(input logic [63:0] v, input logic [15:0] bi);
    logic [31:0] lo, hi;
    logic [63:0] d, exp;
    set_count(v);
    wr(A_IVAL, 32'(bi));
    wr(A_CTRL, 32'h8);
    repeat (70) @(negedge clk);
    rd(A_TGT_LO, lo);
    rd(A_TGT_HI, hi);
    d = 64'(bi) * 64'd1024;
    exp = (bi == 0) ? v : (v / d + 64'd1) * d;
    chk("R7 rounded target", {hi, lo}, exp);
  endtask

  initial begin
    logic [31:0] r, r2;
    logic [63:0] vals [6] = '{64'd0, 64'd1023, 64'd1024, 64'd102399,
                              64'h0000_0012_3456_789A, 64'hFFFF_FFFF_0000_0000};
    logic [15:0] bis [5] = '{16'd1, 16'd3, 16'd100, 16'hFFFF, 16'd0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", tsf, 64'd0);
    chk("R8 no due at reset", 64'(due), 64'd0);
    rd(A_CTRL, r);
    chk("R7 idle status", 64'(r), 64'd0);

    // R1 ticking
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    chk("R1 ten ticks", tsf, 64'd10);
    repeat (5) @(negedge clk);
    chk("R1 hold without tick", tsf, 64'd10);

    // R5 halves do not touch the count
    wr(A_OFS_LO, 32'hDEAD_0001);
    wr(A_OFS_HI, 32'h0000_0002);
    wr(A_TGT_LO, 32'h1234_5678);
    wr(A_TGT_HI, 32'h9ABC_DEF0);
    repeat (3) @(negedge clk);
    chk("R5 count untouched", tsf, 64'd10);
    rd(A_OFS_LO, r); rd(A_OFS_HI, r2);
    chk("R5 offset readback", {r2, r}, 64'h0000_0002_DEAD_0001);
    rd(A_TGT_LO, r); rd(A_TGT_HI, r2);
    chk("R5 target readback", {r2, r}, 64'h9ABC_DEF0_1234_5678);

    // R4 offset sync
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, r);
    chk("R4 sync bit clears", 64'(r[1]), 64'd0);
    chk("R4 added value", tsf, 64'h0000_0002_DEAD_000B);

    // R6 latch
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    rd(A_CTRL, r);
    chk("R6 latch bit clears", 64'(r[0]), 64'd0);
    rd(A_SNAP_LO, r); rd(A_SNAP_HI, r2);
    chk("R6 snapshot", {r2, r}, 64'h0000_0002_DEAD_000B);

    // R2/R3 offset helper across all rates
    set_count(64'h0000_0100_0000_0000);
    bcn_valid = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      bcn_rate = 8'(k);
      bcn_ts = tsf + 64'd1000;
      #1;
      chk("R2 corrected offset", calc_ofs, 64'd1000 - lat_ref(k));
      chk("R3 apply on differing ts", 64'(calc_apply), 64'd1);
    end
    @(negedge clk);
    bcn_rate = 8'd200;
    bcn_ts = tsf - 64'd5;
    #1 chk("R2 negative wrap", calc_ofs, 64'd0 - 64'd5 - lat_ref(200));
    bcn_ts = tsf;
    #1 chk("R3 equal ts no apply", 64'(calc_apply), 64'd0);
    bcn_ts = tsf + 64'd7;
    bcn_valid = 1'b0;
    #1 chk("R3 not valid no apply", 64'(calc_apply), 64'd0);

    // R7 rounding grid
    foreach (bis[b]) foreach (vals[v]) calc_check(vals[v], bis[b]);
    calc_check(64'd102400, 16'd100);

    // R9 start while busy ignored, busy length
    set_count(64'd777_777);
    wr(A_IVAL, 32'd100);
    wr(A_CTRL, 32'h8);
    chk("R7 busy after start", 64'(busy), 64'd1);
    wr(A_IVAL, 32'd3);
    wr(A_CTRL, 32'h8);
    repeat (59) @(negedge clk);
    chk("R9 still busy at 63", 64'(busy), 64'd1);
    @(negedge clk);
    chk("R9 busy ends at 64", 64'(busy), 64'd0);
    @(negedge clk);
    rd(A_TGT_LO, r); rd(A_TGT_HI, r2);
    chk("R9 result of first start", {r2, r}, 64'd819200);

    // R8 beacon due
    chk("R8 no due before arming", 64'(due_seen), 64'd0);
    set_count(64'd5000);
    wr(A_IVAL, 32'd1);
    wr(A_CTRL, 32'h8);
    repeat (70) @(negedge clk);
    wr(A_CTRL, 32'h4);
    @(negedge clk);
    tick = 1'b1;
    while (tsf < 64'd6200) @(negedge clk);
    tick = 1'b0;
    chk("R8 pulse count", 64'(due_seen), 64'd2);
    chk("R8 first pulse", due_at[0], 64'd5121);
    chk("R8 advanced pulse", due_at[1], 64'd6145);

    summary();
  end
endmodule